// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog peripheral on a simple one-cycle register bus. A down-counter moves by one on each cycle where `tick_en` is high. Software keeps the system alive by writing a restart command that carries an 8-bit key. If the counter runs past zero, or software restarts it too early, the block records the fault in a status register. It then raises either a level interrupt or a one-cycle reset pulse, depending on the mode.

The mode register holds several fields:
- the reload value,
- a window limit (a restart is legal only once the count has fallen to or below it),
- an enable for the interrupt and an enable for the reset pulse,
- a disable bit,
- two freeze enables, one tied to the `cpu_idle` input and one to the `cpu_debug` input.

The reload and window fields are protected while the timer is disabled. To change them, software first clears the disable bit and then writes the new values. At 256 ticks per second, a timeout of N seconds takes a reload of N*256-1, for N from 1 to 16.

Bus access is a single cycle. With `bus_sel` high, `bus_wr` picks a write or a read of the register at `bus_addr`. The offsets are 0x0 for control, 0x4 for mode and 0x8 for status. Read data is combinational in the access cycle.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, mode reads 0x0FFF_AFFF, status reads 0, and `irq_o` and `rst_pulse_o` are low. Mode bits: reload [11:0], irq enable [12], reset enable [13], disable [15], window [27:16], idle freeze [28], debug freeze [29]; other bits read 0.
- R2: A mode write made while the stored disable bit is 1 leaves reload and window unchanged, while the flag bits still update.
- R3: A mode write made while the stored disable bit is 0 stores all fields and loads the counter with the new reload value.
- R4: While enabled and not frozen, each tick decrements the count. The tick taken at count 0 is an underflow: it sets status bit 0 and reloads, so the first underflow comes on tick reload+1.
- R5: A control write (offset 0x0) restarts the counter only if bits 31:24 equal 0xA5 and bit 0 is 1; any other control write has no effect.
- R6: A keyed restart while the count is above the window field sets status bit 1. A restart at or below the window sets nothing. Both reload the counter.
- R7: While the disable bit is 1, the counter does not run and no fault of either kind is raised.
- R8: With the idle (or debug) freeze bit set and `cpu_idle` (or `cpu_debug`) high, ticks do not move the counter.
- R9: Status (offset 0x8) reads nonzero after a fault, and a status read clears it to 0.
- R10: With irq enable set, `irq_o` is high while status is nonzero and drops once status is read.
- R11: With reset enable set, every fault gives a `rst_pulse_o` pulse of exactly one cycle, in the cycle after the fault edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable strobe, one count per high cycle |
| cpu_idle | input | 1 | Processor idle indication |
| cpu_debug | input | 1 | Processor halted-in-debug indication |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level fault interrupt |
| rst_pulse_o | output | 1 | One-cycle fault reset request |

## Verification
The embedded assertions check the following on every cycle:
- the reload and window fields hold across any mode write made while disabled;
- no fault appears while disabled;
- a running count drops by exactly one per effective tick;
- the interrupt falls only after a status read or a mode change;
- a reset pulse never appears without a recorded status bit.

Only the bench scenarios can show the rest:
- that the key and restart bit are both required;
- the exact underflow tick count;
- which side of the window limit is legal;
- that freeze and clear-on-read work end to end through the bus.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int          FIELD_MAX = 12;
   localparam logic [7:0]  OFF_CTRL  = 8'h00;
   localparam logic [7:0]  OFF_MODE  = 8'h04;
   localparam logic [7:0]  OFF_STAT  = 8'h08;
   localparam logic [7:0]  KEY_VAL   = 8'hA5;
   localparam int          KEY_LSB   = 24;
   localparam int          BIT_GO    = 0;
   localparam int          BIT_IRQEN = 12;
   localparam int          BIT_RSTEN = 13;
   localparam int          BIT_DIS   = 15;
   localparam int          WIN_LSB   = 16;
   localparam int          BIT_IDLE  = 28;
   localparam int          BIT_DBG   = 29;
   localparam int          ST_UF     = 0;
   localparam int          ST_WIN    = 1;
   localparam int          ST_W      = 2;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [ST_W-1:0]   status,
   output logic [31:0]       bus_rdata,
   output logic [CNT_W-1:0]  reload_q,
   output logic [CNT_W-1:0]  window_q,
   output logic              irq_en_q,
   output logic              rst_en_q,
   output logic              dis_q,
   output logic              idle_frz_q,
   output logic              dbg_frz_q,
   output logic              restart,
   output logic              load,
   output logic              mode_wr,
   output logic              stat_rd
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   logic ctrl_wr;

   always_comb begin
      ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
      mode_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_MODE));
      stat_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
      restart = ctrl_wr && (bus_wdata[KEY_LSB +: 8] == KEY_VAL) && bus_wdata[BIT_GO];
      load    = mode_wr && !dis_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q   <= MAXV;
         window_q   <= MAXV;
         irq_en_q   <= 1'b0;
         rst_en_q   <= 1'b1;
         dis_q      <= 1'b1;
         idle_frz_q <= 1'b0;
         dbg_frz_q  <= 1'b0;
      end else if (mode_wr) begin
         irq_en_q   <= bus_wdata[BIT_IRQEN];
         rst_en_q   <= bus_wdata[BIT_RSTEN];
         dis_q      <= bus_wdata[BIT_DIS];
         idle_frz_q <= bus_wdata[BIT_IDLE];
         dbg_frz_q  <= bus_wdata[BIT_DBG];
         if (!dis_q) begin
            reload_q <= bus_wdata[CNT_W-1:0];
            window_q <= bus_wdata[WIN_LSB +: CNT_W];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (bus_addr == ADDR_W'(OFF_MODE)) begin
            bus_rdata[CNT_W-1:0]         = reload_q;
            bus_rdata[WIN_LSB +: CNT_W]  = window_q;
            bus_rdata[BIT_IRQEN]         = irq_en_q;
            bus_rdata[BIT_RSTEN]         = rst_en_q;
            bus_rdata[BIT_DIS]           = dis_q;
            bus_rdata[BIT_IDLE]          = idle_frz_q;
            bus_rdata[BIT_DBG]           = dbg_frz_q;
         end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
            bus_rdata[ST_W-1:0] = status;
         end
      end
   end

   // R2
   field_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && dis_q) |=> ($stable(reload_q) && $stable(window_q)));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             frozen,
   input  logic             dis,
   input  logic [CNT_W-1:0] reload,
   input  logic [CNT_W-1:0] window,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load,
   input  logic             restart,
   output logic             uf_evt,
   output logic             win_evt
);
   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   always_comb begin
      step    = tick_en && !frozen && !dis && !load && !restart;
      uf_evt  = step && (cnt_q == '0);
      win_evt = restart && !dis && (cnt_q > window);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= MAXV;
      else if (load)          cnt_q <= load_val;
      else if (dis || restart) cnt_q <= reload;
      else if (step)          cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
   end

   // R7
   quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis |-> (!uf_evt && !win_evt));

   // R4
   dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !frozen && !dis && !load && !restart && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wdog_fault.sv
module wdog_fault
   import wdog_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            uf_evt,
   input  logic            win_evt,
   input  logic            stat_rd,
   input  logic            mode_wr,
   input  logic            irq_en,
   input  logic            rst_en,
   output logic [ST_W-1:0] status_q,
   output logic            irq_o,
   output logic            rst_pulse_o
);
   logic [ST_W-1:0] set_v;

   always_comb begin
      set_v         = '0;
      set_v[ST_UF]  = uf_evt;
      set_v[ST_WIN] = win_evt;
      irq_o         = irq_en && (|status_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q    <= '0;
         rst_pulse_o <= 1'b0;
      end else begin
         status_q    <= (stat_rd ? '0 : status_q) | set_v;
         rst_pulse_o <= rst_en && (|set_v);
      end
   end

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> ($past(stat_rd) || $past(mode_wr)));

   // R11
   pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse_o |-> (|status_q));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
   import wdog_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              cpu_idle,
   input  logic              cpu_debug,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o,
   output logic              rst_pulse_o
);
   if (CNT_W < 2 || CNT_W > FIELD_MAX) begin : g_bad_cnt_w
      $error("wdog_keyed: CNT_W must be in 2..12");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("wdog_keyed: ADDR_W must be at least 4");
   end

   logic [CNT_W-1:0] reload_q, window_q;
   logic             irq_en_q, rst_en_q, dis_q, idle_frz_q, dbg_frz_q;
   logic             restart, load, mode_wr, stat_rd;
   logic             uf_evt, win_evt, frozen;
   logic [ST_W-1:0]  status_q;

   assign frozen = (idle_frz_q && cpu_idle) || (dbg_frz_q && cpu_debug);

   wdog_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status_q),
      .bus_rdata(bus_rdata), .reload_q(reload_q), .window_q(window_q),
      .irq_en_q(irq_en_q), .rst_en_q(rst_en_q), .dis_q(dis_q),
      .idle_frz_q(idle_frz_q), .dbg_frz_q(dbg_frz_q), .restart(restart),
      .load(load), .mode_wr(mode_wr), .stat_rd(stat_rd)
   );

   wdog_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .frozen(frozen),
      .dis(dis_q), .reload(reload_q), .window(window_q),
      .load_val(bus_wdata[CNT_W-1:0]), .load(load), .restart(restart),
      .uf_evt(uf_evt), .win_evt(win_evt)
   );

   wdog_fault fault_i (
      .clk(clk), .rst_n(rst_n), .uf_evt(uf_evt), .win_evt(win_evt),
      .stat_rd(stat_rd), .mode_wr(mode_wr), .irq_en(irq_en_q),
      .rst_en(rst_en_q), .status_q(status_q), .irq_o(irq_o),
      .rst_pulse_o(rst_pulse_o)
   );
endmodule

// File: tb/wdog_keyed_tb_top.sv
`timescale 1ns/100ps
module wdog_keyed_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, cpu_idle = 1'b0, cpu_debug = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, rst_pulse_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct { logic [31:0] v; string tag; } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   wdog_keyed dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_idle(cpu_idle),
      .cpu_debug(cpu_debug), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .rst_pulse_o(rst_pulse_o)
   );

   // monitor: compare every read against the scoreboard
   always @(negedge clk) begin
      if (bus_sel && !bus_wr) begin
         exp_t e;
         checks++;
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty: got %h expected none", bus_rdata);
         end else begin
            e = sb_q.pop_front();
            if (bus_rdata !== e.v) begin
               errors++;
               $display("FAIL %s: got %h expected %h", e.tag, bus_rdata, e.v);
            end
         end
      end
   end

   function automatic logic [31:0] mk(input logic [11:0] rl, input logic [11:0] wn,
      input bit ie, input bit re, input bit ds, input bit ih, input bit dh);
      logic [31:0] m;
      m = '0;
      m[11:0] = rl; m[27:16] = wn;
      m[12] = ie; m[13] = re; m[15] = ds; m[28] = ih; m[29] = dh;
      return m;
   endfunction

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string tag);
      exp_t x;
      x.v = e; x.tag = tag;
      sb_q.push_back(x);
      @(posedge clk); #1;
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      @(posedge clk); #1;
      bus_sel = 0;
   endtask

   task automatic ticks(input int n);
      @(posedge clk); #1;
      tick_en = 1;
      repeat (n) @(posedge clk);
      #1 tick_en = 0;
   endtask

   task automatic chk(input logic got, input logic e, input string tag);
      checks++;
      if (got !== e) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, e);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5ns * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      chk(irq_o, 0, "R1 irq after reset");
      chk(rst_pulse_o, 0, "R1 rst pulse after reset");
      bus_read(4'h4, 32'h0FFF_AFFF, "R1 mode reset value");
      bus_read(4'h8, 32'h0, "R1 status reset value");

      // R2 locked fields while disabled
      bus_write(4'h4, mk(12'd5, 12'd2, 1, 1, 1, 0, 0));
      bus_read(4'h4, 32'h0FFF_BFFF, "R2 fields locked, flags updated");

      // R7 disabled: no counting, no fault
      ticks(5000);
      bus_read(4'h8, 32'h0, "R7 no fault while disabled");

      // R3 unlock then program
      bus_write(4'h4, mk(12'd0, 12'd0, 1, 0, 0, 0, 0));
      bus_write(4'h4, mk(12'd5, 12'd2, 1, 0, 0, 0, 0));
      bus_read(4'h4, 32'h0002_1005, "R3 fields stored after enable");

      // R5 wrong key ignored, R4 underflow on tick reload+1
      ticks(4);
      bus_write(4'h0, 32'h5A00_0001);
      ticks(1);
      bus_read(4'h8, 32'h0, "R4 no underflow at tick reload");
      ticks(1);
      chk(irq_o, 1, "R10 irq after underflow");
      bus_read(4'h8, 32'h1, "R5 bad key ignored, R9 underflow status");
      chk(irq_o, 0, "R10 irq cleared by read");
      bus_read(4'h8, 32'h0, "R9 status cleared by read");

      // R6 legal restart at window boundary
      ticks(3);
      bus_write(4'h0, 32'hA500_0001);
      bus_read(4'h8, 32'h0, "R6 restart at window is clean");
      ticks(5);
      bus_read(4'h8, 32'h0, "R6 restart reloaded counter");
      // R5 key without restart bit ignored
      bus_write(4'h0, 32'hA500_0000);
      ticks(1);
      bus_read(4'h8, 32'h1, "R5 key without go bit ignored");

      // R6 early restart is a fault
      bus_write(4'h0, 32'hA500_0001);
      chk(irq_o, 1, "R10 irq on window fault");
      bus_read(4'h8, 32'h2, "R6 early restart sets bit1");

      // R11 reset pulse action
      bus_write(4'h4, mk(12'd5, 12'd2, 0, 1, 0, 0, 0));
      bus_write(4'h0, 32'hA500_0001);
      chk(rst_pulse_o, 1, "R11 reset pulse asserted");
      chk(irq_o, 0, "R11 no irq when irq disabled");
      @(posedge clk); #1;
      chk(rst_pulse_o, 0, "R11 reset pulse one cycle");
      bus_read(4'h8, 32'h2, "R11 status on reset action");

      // R8 freeze in idle and debug
      bus_write(4'h4, mk(12'd5, 12'd5, 1, 0, 0, 1, 1));
      cpu_idle = 1;
      ticks(10);
      bus_read(4'h8, 32'h0, "R8 idle freeze holds count");
      cpu_idle = 0; cpu_debug = 1;
      ticks(10);
      bus_read(4'h8, 32'h0, "R8 debug freeze holds count");
      cpu_debug = 0;
      ticks(5);
      bus_read(4'h8, 32'h0, "R8 count resumes at reload");
      ticks(1);
      bus_read(4'h8, 32'h1, "R8 underflow after release");

      // R7 disable from running, R2 lock again
      bus_write(4'h4, mk(12'd5, 12'd5, 1, 0, 1, 0, 0));
      ticks(20);
      bus_read(4'h8, 32'h0, "R7 disabled stops counting");
      bus_write(4'h4, mk(12'd7, 12'd7, 1, 0, 1, 0, 0));
      bus_read(4'h4, 32'h0005_9005, "R2 fields locked after disable");

      repeat (2) @(posedge clk);
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
      end
      finish_run();
   end
endmodule